// File: doc/BRIEF.md
# DMA Channel Run/Stop Controller

This block decides, cycle by cycle, whether one DMA channel may move data. Software arms the channel through a small write port. The same write sets the request source, the transfer shape, the number of transfers and the block length. While the channel's run flag is set, the block drives one strobe per unit of data toward an address/datapath unit outside this block. It keeps that strobe going until the programmed work is done, software stops it, or a hardware condition forces it off.

Two request sources are supported. In self-paced mode a unit moves every cycle once the flag is up. In request-paced mode a unit moves only on a cycle where the request line is high. Two transfer shapes are supported. In single mode each strobe is one counted transfer. In block mode one trigger produces a burst of strobes, one for each unit of the block, and the count then drops by one. A software stop in block mode waits for the running burst to finish. An abort line, a repeat-area overflow, an NMI pulse, a standby input and reset all stop the channel at once. The count, the two mode bits and the run flag can be read back at the ports.

Top module: `dma_run_ctrl`

## Requirements
- R1: A write with `sw_run`=1 while the flag is 0 loads the mode bits, the count and the block length, and the flag reads 1 from the next cycle. If the written count is 0, the flag stays 0.
- R2: In self-paced mode (`sw_ext_mode`=0), `xfer_stb` is high in every cycle in which the flag is 1 and no halt input is high, starting in the first cycle the flag reads 1.
- R3: In request-paced mode (`sw_ext_mode`=1) and outside a running block, `xfer_stb` is high exactly in the cycles where `ext_req` is high and the flag is 1. A request seen while the flag is 0 is not remembered.
- R4: In single mode (`sw_blk_mode`=0), each strobe lowers `count_rd` by one. After the strobe that takes the count from 1 to 0, the flag reads 0.
- R5: In block mode (`sw_blk_mode`=1), each trigger yields L consecutive strobes, where L is the block length and a written length of 0 counts as 1. `count_rd` drops by one per completed block. Requests during a running block are ignored.
- R6: In single mode, a write with `sw_run`=0 while the flag is 1 clears the flag from the next cycle, and no further strobes follow.
- R7: In block mode, a write with `sw_run`=0 during a block leaves the flag at 1 and the strobes running until the block's last unit. The flag reads 0 from the cycle after that unit.
- R8: While `ext_abort`, `rpt_ovf`, `nmi` or `standby` is high, `xfer_stb` is low, and the flag reads 0 from the next cycle. Any partly done block is abandoned, so a later start begins a fresh block.
- R9: While the flag is 1, a write with `sw_run`=1 has no effect. The mode and count fields of any write are ignored.
- R10: `done_pulse` is high for exactly one cycle, the first cycle the flag reads 0 after the count reaches 0. It never fires on a stop by software or by a halt input.
- R11: After reset, the flag is 0, `xfer_stb` and `done_pulse` are 0, `count_rd` is 0, and both mode readbacks are 0 (self-paced, single).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_we | input | 1 | Software write strobe for the control word |
| sw_run | input | 1 | Run flag value being written |
| sw_ext_mode | input | 1 | 1 = request-paced, 0 = self-paced |
| sw_blk_mode | input | 1 | 1 = block shape, 0 = single shape |
| sw_count | input | CNT_W | Transfers (single) or blocks (block) to perform |
| sw_blk_len | input | BLK_W | Units per block, 0 treated as 1 |
| ext_req | input | 1 | External transfer request |
| ext_abort | input | 1 | External abort, stops at once |
| rpt_ovf | input | 1 | Repeat-area overflow halt |
| nmi | input | 1 | Non-maskable interrupt halt |
| standby | input | 1 | Standby entry halt |
| xfer_stb | output | 1 | One unit transfer this cycle |
| run_flag | output | 1 | Channel active flag |
| done_pulse | output | 1 | Count exhausted, one cycle |
| count_rd | output | CNT_W | Remaining transfers or blocks |
| ext_mode_rd | output | 1 | Readback of request mode |
| blk_mode_rd | output | 1 | Readback of transfer shape |

## Verification
The bench first sweeps count against block length and checks that the number of strobes is the product of the two. A design that counted strobes instead of blocks, or that mishandled a zero length, would stop early or run long. It holds the request line high before arming and during a burst; a design that latched either request would produce extra strobes. It issues a software stop mid-block and checks that the flag stays up for exactly the rest of the burst; a design that stopped at once would cut the burst short, and one that ignored the stop would start the next block. It fires each halt source mid-run and then re-arms in block mode, which exposes a design that strobes during the halt cycle, raises the completion pulse on a halt, or keeps a stale partial block.

// File: rtl/dma_run_pkg.sv
`timescale 1ns/1ps
package dma_run_pkg;

    typedef enum logic {
        REQ_AUTO = 1'b0,
        REQ_EXT  = 1'b1
    } req_mode_e;

    typedef enum logic {
        XM_SINGLE = 1'b0,
        XM_BLOCK  = 1'b1
    } xfer_mode_e;

    typedef struct packed {
        req_mode_e  req;
        xfer_mode_e shape;
    } chan_mode_t;

    localparam chan_mode_t MODE_RESET = '{req: REQ_AUTO, shape: XM_SINGLE};

    function automatic logic halt_any(input logic abort_l, input logic ovf_l,
                                      input logic nmi_l, input logic stby_l);
        return abort_l | ovf_l | nmi_l | stby_l;
    endfunction

endpackage

// File: rtl/dma_run_cfg.sv
`timescale 1ns/1ps
module dma_run_cfg
    import dma_run_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  chan_mode_t       mode_in,
    input  logic [CNT_W-1:0] cnt_in,
    input  logic             dec,
    output chan_mode_t       mode,
    output logic [CNT_W-1:0] cnt,
    output logic             last
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= MODE_RESET;
            cnt  <= '0;
        end else if (load) begin
            mode <= mode_in;
            cnt  <= cnt_in;
        end else if (dec && cnt != '0) begin
            cnt <= cnt - ONE;
        end
    end

    assign last = dec && (cnt == ONE);

endmodule

// File: rtl/dma_run_blk.sv
`timescale 1ns/1ps
module dma_run_blk #(
    parameter int BLK_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [BLK_W-1:0] len_in,
    input  logic             blk_mode,
    input  logic             xfer,
    input  logic             kill,
    output logic             in_blk,
    output logic             blk_end,
    output logic             busy_next
);
    localparam logic [BLK_W-1:0] ONE = BLK_W'(1);

    logic [BLK_W-1:0] len_q;
    logic [BLK_W-1:0] left_q;
    logic [BLK_W-1:0] len_eff;

    always_comb begin
        len_eff   = (len_q == '0) ? ONE : len_q;
        in_blk    = (left_q != '0);
        blk_end   = blk_mode && xfer && (in_blk ? (left_q == ONE) : (len_eff == ONE));
        busy_next = blk_mode && (in_blk ? (left_q > ONE) : (xfer && len_eff > ONE));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q  <= '0;
            left_q <= '0;
        end else begin
            if (load) len_q <= len_in;
            if (kill) begin
                left_q <= '0;
            end else if (blk_mode && xfer) begin
                left_q <= in_blk ? (left_q - ONE) : (len_eff - ONE);
            end
        end
    end

endmodule

// File: rtl/dma_run_ctrl.sv
`timescale 1ns/1ps
module dma_run_ctrl
    import dma_run_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int BLK_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sw_we,
    input  logic             sw_run,
    input  logic             sw_ext_mode,
    input  logic             sw_blk_mode,
    input  logic [CNT_W-1:0] sw_count,
    input  logic [BLK_W-1:0] sw_blk_len,
    input  logic             ext_req,
    input  logic             ext_abort,
    input  logic             rpt_ovf,
    input  logic             nmi,
    input  logic             standby,
    output logic             xfer_stb,
    output logic             run_flag,
    output logic             done_pulse,
    output logic [CNT_W-1:0] count_rd,
    output logic             ext_mode_rd,
    output logic             blk_mode_rd
);
    logic       run_q, stop_q, done_q;
    logic       kill, load, dec, cnt_last;
    logic       in_blk, blk_end, busy_next;
    logic       is_blk, may_start;
    chan_mode_t mode_in, mode;

    assign kill    = halt_any(ext_abort, rpt_ovf, nmi, standby);
    assign load    = sw_we && !run_q;
    assign mode_in = '{req: req_mode_e'(sw_ext_mode), shape: xfer_mode_e'(sw_blk_mode)};
    assign is_blk  = (mode.shape == XM_BLOCK);

    always_comb begin
        may_start = !stop_q && ((mode.req == REQ_AUTO) || ext_req);
        xfer_stb  = !kill && run_q && (in_blk || may_start);
        dec       = is_blk ? blk_end : xfer_stb;
    end

    dma_run_cfg #(.CNT_W(CNT_W)) cfg_i (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .mode_in (mode_in),
        .cnt_in  (sw_count),
        .dec     (dec),
        .mode    (mode),
        .cnt     (count_rd),
        .last    (cnt_last)
    );

    dma_run_blk #(.BLK_W(BLK_W)) blk_i (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .len_in    (sw_blk_len),
        .blk_mode  (is_blk),
        .xfer      (xfer_stb),
        .kill      (kill),
        .in_blk    (in_blk),
        .blk_end   (blk_end),
        .busy_next (busy_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            stop_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (kill) begin
                run_q  <= 1'b0;
                stop_q <= 1'b0;
            end else if (run_q && cnt_last) begin
                run_q  <= 1'b0;
                stop_q <= 1'b0;
                done_q <= 1'b1;
            end else if (run_q && stop_q && blk_end) begin
                run_q  <= 1'b0;
                stop_q <= 1'b0;
            end else if (sw_we && run_q && !sw_run) begin
                if (busy_next) begin
                    stop_q <= 1'b1;
                end else begin
                    run_q  <= 1'b0;
                    stop_q <= 1'b0;
                end
            end else if (load && sw_run && sw_count != '0) begin
                run_q <= 1'b1;
            end
        end
    end

    assign run_flag    = run_q;
    assign done_pulse  = done_q;
    assign ext_mode_rd = (mode.req == REQ_EXT);
    assign blk_mode_rd = is_blk;

endmodule

// File: rtl/dma_run_chk.sv
`timescale 1ns/1ps
module dma_run_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             ext_abort,
    input logic             rpt_ovf,
    input logic             nmi,
    input logic             standby,
    input logic             xfer_stb,
    input logic             run_flag,
    input logic             done_pulse,
    input logic [CNT_W-1:0] count_rd,
    input logic             ext_mode_rd,
    input logic             blk_mode_rd
);
    logic halt_seen;
    assign halt_seen = ext_abort | rpt_ovf | nmi | standby;

    p_strobe_needs_flag_r2: assert property (@(posedge clk) disable iff (rst)
        xfer_stb |-> run_flag);

    p_halt_mutes_strobe_r8: assert property (@(posedge clk) disable iff (rst)
        halt_seen |-> !xfer_stb);

    p_halt_clears_flag_r8: assert property (@(posedge clk) disable iff (rst)
        halt_seen |=> !run_flag);

    p_done_one_cycle_r10: assert property (@(posedge clk) disable iff (rst)
        done_pulse |=> !done_pulse);

    p_done_at_fall_r10: assert property (@(posedge clk) disable iff (rst)
        done_pulse |-> (!run_flag && $past(run_flag)));

    p_mode_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        run_flag |=> ($stable(ext_mode_rd) && $stable(blk_mode_rd)));

    p_count_never_rises_r9: assert property (@(posedge clk) disable iff (rst)
        run_flag |=> (count_rd <= $past(count_rd)));

endmodule

bind dma_run_ctrl dma_run_chk #(.CNT_W(CNT_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .ext_abort   (ext_abort),
    .rpt_ovf     (rpt_ovf),
    .nmi         (nmi),
    .standby     (standby),
    .xfer_stb    (xfer_stb),
    .run_flag    (run_flag),
    .done_pulse  (done_pulse),
    .count_rd    (count_rd),
    .ext_mode_rd (ext_mode_rd),
    .blk_mode_rd (blk_mode_rd)
);

// File: tb/dma_run_ctrl_tb.sv
`timescale 1ns/1ps
module dma_run_ctrl_tb_top;
    localparam int CNT_W = 8;
    localparam int BLK_W = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sw_we = 0, sw_run = 0, sw_ext_mode = 0, sw_blk_mode = 0;
    logic [CNT_W-1:0] sw_count = '0;
    logic [BLK_W-1:0] sw_blk_len = '0;
    logic ext_req = 0, ext_abort = 0, rpt_ovf = 0, nmi = 0, standby = 0;
    logic xfer_stb, run_flag, done_pulse, ext_mode_rd, blk_mode_rd;
    logic [CNT_W-1:0] count_rd;

    int total = 0, bad = 0;
    int n_str = 0, n_dn = 0, n_act = 0;
    bit fin = 0;

    always #10 clk = ~clk;

    dma_run_ctrl #(.CNT_W(CNT_W), .BLK_W(BLK_W)) dut_i (
        .clk(clk), .rst(rst), .sw_we(sw_we), .sw_run(sw_run),
        .sw_ext_mode(sw_ext_mode), .sw_blk_mode(sw_blk_mode),
        .sw_count(sw_count), .sw_blk_len(sw_blk_len), .ext_req(ext_req),
        .ext_abort(ext_abort), .rpt_ovf(rpt_ovf), .nmi(nmi), .standby(standby),
        .xfer_stb(xfer_stb), .run_flag(run_flag), .done_pulse(done_pulse),
        .count_rd(count_rd), .ext_mode_rd(ext_mode_rd), .blk_mode_rd(blk_mode_rd)
    );

    task automatic chk(input bit ok, input string tag, input int actv, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, actv, expv);
        end
    endtask

    task automatic cyc();
        #2;
        if (xfer_stb)   n_str++;
        if (done_pulse) n_dn++;
        if (run_flag)   n_act++;
        @(negedge clk);
    endtask

    task automatic clr();
        n_str = 0; n_dn = 0; n_act = 0;
    endtask

    task automatic prog(input bit run, input bit ext, input bit blk, input int cnt, input int len);
        sw_we = 1; sw_run = run; sw_ext_mode = ext; sw_blk_mode = blk;
        sw_count = CNT_W'(cnt); sw_blk_len = BLK_W'(len);
        cyc();
        sw_we = 0;
    endtask

    task automatic run_out(input int limit);
        for (int i = 0; i < limit && run_flag; i++) cyc();
        cyc();
    endtask

    task automatic set_halt(input int src, input bit v);
        case (src)
            0: ext_abort = v;
            1: rpt_ovf   = v;
            2: nmi       = v;
            default: standby = v;
        endcase
    endtask

    initial begin
        #(20 * 100000);
        if (!fin) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #2;
        chk(run_flag == 0 && xfer_stb == 0 && done_pulse == 0, "R11 reset outputs", int'(run_flag), 0);
        chk(count_rd == 0 && ext_mode_rd == 0 && blk_mode_rd == 0, "R11 reset readback", int'(count_rd), 0);
        @(negedge clk);
        rst = 0;

        // R2 R4 R10: self-paced single sweep
        for (int c = 1; c <= 6; c++) begin
            prog(1, 0, 0, c, 0);
            clr();
            chk(run_flag == 1, "R1 flag set", int'(run_flag), 1);
            #1;
            chk(xfer_stb == 1, "R2 first strobe", int'(xfer_stb), 1);
            run_out(40);
            chk(n_str == c, "R4 strobe count single", n_str, c);
            chk(n_act == c, "R2 strobe every active cycle", n_act, c);
            chk(n_dn == 1, "R10 one done pulse", n_dn, 1);
            chk(count_rd == 0, "R4 count exhausted", int'(count_rd), 0);
        end

        // R5: self-paced block sweep, length 0 counts as 1
        for (int len = 0; len <= 3; len++) begin
            for (int c = 1; c <= 3; c++) begin
                int expv;
                expv = c * ((len == 0) ? 1 : len);
                prog(1, 0, 1, c, len);
                clr();
                run_out(40);
                chk(n_str == expv, "R5 block strobes", n_str, expv);
                chk(n_act == expv, "R5 flag span", n_act, expv);
                chk(n_dn == 1, "R10 block done", n_dn, 1);
            end
        end

        // R1: zero count does not arm
        prog(1, 0, 0, 0, 0);
        clr();
        chk(run_flag == 0, "R1 zero count", int'(run_flag), 0);
        repeat (3) cyc();
        chk(n_str == 0, "R1 zero count strobes", n_str, 0);

        // R3: request-paced single
        ext_req = 1;
        repeat (3) cyc();
        ext_req = 0;
        prog(1, 1, 0, 4, 0);
        clr();
        repeat (3) cyc();
        chk(n_str == 0, "R3 early request not kept", n_str, 0);
        for (int i = 0; i < 12; i++) begin
            ext_req = (i % 2 == 0);
            cyc();
        end
        ext_req = 0;
        cyc();
        chk(n_str == 4, "R3 strobes follow requests", n_str, 4);
        chk(n_dn == 1 && run_flag == 0, "R3 ext single done", n_dn, 1);

        // R5: request-paced block, requests inside block ignored
        prog(1, 1, 1, 2, 3);
        clr();
        repeat (2) cyc();
        ext_req = 1; cyc();
        ext_req = 0; cyc();
        ext_req = 1; cyc();
        ext_req = 0;
        chk(n_str == 3, "R5 first block", n_str, 3);
        chk(count_rd == 1 && run_flag == 1, "R5 one block left", int'(count_rd), 1);
        repeat (2) cyc();
        chk(n_str == 3, "R5 in-block request ignored", n_str, 3);
        ext_req = 1; cyc();
        ext_req = 0;
        repeat (4) cyc();
        chk(n_str == 6 && n_dn == 1, "R5 second block done", n_str, 6);
        chk(run_flag == 0, "R5 flag cleared", int'(run_flag), 0);

        // R6: software clear in single mode
        prog(1, 0, 0, 10, 0);
        clr();
        repeat (3) cyc();
        sw_we = 1; sw_run = 0;
        cyc();
        sw_we = 0;
        chk(run_flag == 0, "R6 flag cleared", int'(run_flag), 0);
        repeat (3) cyc();
        chk(n_str == 4, "R6 strobes stop", n_str, 4);
        chk(count_rd == 6 && n_dn == 0, "R6 count kept no done", int'(count_rd), 6);

        // R7: software clear deferred in block mode
        prog(1, 0, 1, 5, 4);
        clr();
        cyc();
        sw_we = 1; sw_run = 0;
        cyc();
        sw_we = 0;
        chk(run_flag == 1, "R7 flag held unit3", int'(run_flag), 1);
        cyc();
        chk(run_flag == 1, "R7 flag held unit4", int'(run_flag), 1);
        cyc();
        chk(run_flag == 0, "R7 flag falls after block", int'(run_flag), 0);
        repeat (3) cyc();
        chk(n_str == 4 && n_dn == 0, "R7 block finished only", n_str, 4);
        chk(count_rd == 4, "R7 count", int'(count_rd), 4);

        // R8: each halt source
        for (int s = 0; s < 4; s++) begin
            prog(1, 0, 0, 20, 0);
            clr();
            repeat (2) cyc();
            set_halt(s, 1);
            cyc();
            set_halt(s, 0);
            chk(n_str == 2, "R8 strobe muted in halt cycle", n_str, 2);
            chk(run_flag == 0, "R8 halt clears flag", int'(run_flag), 0);
            repeat (3) cyc();
            chk(n_str == 2 && n_dn == 0, "R8 no strobes no done", n_str, 2);
        end

        // R8: abort in block, block abandoned
        prog(1, 0, 1, 3, 4);
        clr();
        cyc();
        ext_abort = 1; cyc();
        ext_abort = 0;
        repeat (2) cyc();
        chk(n_str == 1 && run_flag == 0, "R8 block abort", n_str, 1);
        prog(1, 0, 1, 1, 2);
        clr();
        run_out(20);
        chk(n_str == 2, "R8 fresh block after abort", n_str, 2);

        // R9: writes while active
        prog(1, 1, 0, 5, 0);
        clr();
        sw_we = 1; sw_run = 1; sw_ext_mode = 0; sw_blk_mode = 1; sw_count = 9;
        cyc();
        sw_we = 0;
        chk(count_rd == 5, "R9 count ignored", int'(count_rd), 5);
        chk(ext_mode_rd == 1 && blk_mode_rd == 0, "R9 modes ignored", int'(ext_mode_rd), 1);
        chk(run_flag == 1, "R9 flag unchanged", int'(run_flag), 1);
        repeat (3) cyc();
        chk(n_str == 0, "R9 still request-paced", n_str, 0);
        sw_we = 1; sw_run = 0;
        cyc();
        sw_we = 0;
        chk(run_flag == 0, "R6 clear after R9", int'(run_flag), 0);

        fin = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule